// File: doc/BRIEF.md
# Bused Row-Strobed Register Memory

A four-row, four-bit memory whose rows are flip-flop words sharing one data bus. A decoder takes a two-bit row address, an active-low chip select and a single read/write line and produces two active-low strobes per row. One strobe is the write strobe and the other is the output enable. A row stores data on the low-to-high edge of its write strobe. Only the addressed row drives the bus, and only during a read.

The block runs from one clock. Each row holds a two-state controller. `ROW_IDLE` moves to `ROW_ARMED` when the row's write strobe is seen low at a clock edge. While armed, the row copies `bus_din` into a hold register on every edge at which the strobe is still low. `ROW_ARMED` returns to `ROW_IDLE` at the first edge that sees the strobe high, and that edge commits the hold register into the row. No other transition exists.

The bus is modelled as separate signals: input data, output data and an output-enable flag. A pad ring would turn `bus_dout` into high impedance whenever `bus_drive` is low. The per-row strobes are also brought out as ports so that an enclosing design can observe them.

Top module: `rowbus_mem`

## Requirements
- R1: With `sel_n`=0 and `rd_wr_n`=1, only `oe_strb_n[addr]` is 0, all of `we_strb_n` are 1, `bus_drive` is 1, and `bus_dout` shows the contents of row `addr` in the same cycle.
- R2: With `sel_n`=0 and `rd_wr_n`=0, only `we_strb_n[addr]` is 0, all of `oe_strb_n` are 1, and `bus_drive` is 0.
- R3: With `sel_n`=1, all eight strobes are 1 and `bus_drive` is 0, whatever the values on `addr`, `rd_wr_n` and `bus_din`, and no row changes.
- R4: `addr[0]` is the least significant address bit. `addr`=2'b01 selects row 1 and `addr`=2'b10 selects row 2.
- R5: A row stores the value of `bus_din` sampled at the last clock edge at which its write strobe was low. The new value is visible from the first clock edge at which the strobe is seen high.
- R6: If the read/write line is raised on the row being written, the read in that same cycle shows the previous contents. The new contents appear after the next clock edge.
- R7: If `addr` changes while a write is in progress, the old row commits the data held for it and the newly addressed row starts its own write.
- R8: A row's write strobe and output enable are never both 0, and at most one output enable is 0 at any time.
- R9: A row in `ROW_IDLE` keeps its contents across a clock edge.
- R10: When `bus_drive` is 0, `bus_dout` is all zeros, which stands for the released bus.
- R11: During reset, every row controller is in `ROW_IDLE`. The storage holds no defined value until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the row controllers |
| addr | input | 2 | Row address, bit 0 least significant |
| sel_n | input | 1 | Active-low chip select |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| bus_din | input | 4 | Data arriving from the shared bus |
| bus_dout | output | 4 | Data driven onto the shared bus, zero when released |
| bus_drive | output | 1 | High while a row drives the bus |
| we_strb_n | output | 4 | Per-row active-low write strobes |
| oe_strb_n | output | 4 | Per-row active-low output enables |

## Verification
A commit and a read can fall in the same cycle. The bench provokes this by holding a write to row 1, then raising the read/write line without changing the address. That step raises the write strobe and lowers the output enable of the same row at once. The bench then judges `bus_dout` twice: just after the change, where it must still show the old word, and after the next clock edge, where it must show the new word. A second overlap is an address change during a write: one row commits while another arms in the same edge. The bench judges this by reading back both rows afterwards.

// File: rtl/rowbus_pkg.sv
package rowbus_pkg;
    typedef enum logic [0:0] {
        ROW_IDLE  = 1'b0,
        ROW_ARMED = 1'b1
    } row_state_e;
endpackage

// File: rtl/rowbus_decoder.sv
module rowbus_decoder #(
    parameter int ROWS = 4,
    localparam int AW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic [AW-1:0]   addr,
    input  logic            sel_n,
    input  logic            rd_wr_n,
    output logic [ROWS-1:0] we_strb_n,
    output logic [ROWS-1:0] oe_strb_n
);
    // one comparator per row; strobes idle high
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic hit;
        assign hit          = !sel_n && (addr == AW'(r));
        assign we_strb_n[r] = !(hit && !rd_wr_n);
        assign oe_strb_n[r] = !(hit && rd_wr_n);
    end
endmodule

// File: rtl/rowbus_row.sv
module rowbus_row
    import rowbus_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_n,
    input  logic         oe_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] word,
    output logic         drive
);
    row_state_e   state_q, state_nx;
    logic         commit;
    logic [W-1:0] hold_q;
    logic [W-1:0] word_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ROW_IDLE;
        else        state_q <= state_nx;
    end

    // next state and commit pulse
    always_comb begin
        state_nx = state_q;
        commit   = 1'b0;
        unique case (state_q)
            ROW_IDLE: begin
                if (!we_n) state_nx = ROW_ARMED;
            end
            ROW_ARMED: begin
                if (we_n) begin
                    state_nx = ROW_IDLE;
                    commit   = 1'b1;
                end
            end
            default: state_nx = ROW_IDLE;
        endcase
    end

    // storage: contents deliberately not reset
    always_ff @(posedge clk) begin
        if (!we_n)  hold_q <= din;
        if (commit) word_q <= hold_q;
    end

    assign word  = word_q;
    assign drive = !oe_n;

    // R5
    commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ROW_ARMED && we_n) |=> (word_q == $past(hold_q)));
    // R9
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ROW_IDLE) |=> $stable(word_q));
    // R8
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n || oe_n));
endmodule

// File: rtl/rowbus_merge.sv
module rowbus_merge #(
    parameter int ROWS = 4,
    parameter int W    = 4
) (
    input  logic [ROWS-1:0][W-1:0] words,
    input  logic [ROWS-1:0]        drives,
    output logic [W-1:0]           dout,
    output logic                   dout_en
);
    always_comb begin
        dout = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (drives[r]) dout = dout | words[r];
        end
    end
    assign dout_en = |drives;
endmodule

// File: rtl/rowbus_mem.sv
module rowbus_mem #(
    parameter int ROWS = 4,
    parameter int W    = 4,
    localparam int AW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic            sel_n,
    input  logic            rd_wr_n,
    input  logic [W-1:0]    bus_din,
    output logic [W-1:0]    bus_dout,
    output logic            bus_drive,
    output logic [ROWS-1:0] we_strb_n,
    output logic [ROWS-1:0] oe_strb_n
);
    logic [ROWS-1:0][W-1:0] row_words;
    logic [ROWS-1:0]        row_drives;

    rowbus_decoder #(.ROWS(ROWS)) u_dec (
        .addr      (addr),
        .sel_n     (sel_n),
        .rd_wr_n   (rd_wr_n),
        .we_strb_n (we_strb_n),
        .oe_strb_n (oe_strb_n)
    );

    for (genvar r = 0; r < ROWS; r++) begin : g_rows
        rowbus_row #(.W(W)) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .we_n  (we_strb_n[r]),
            .oe_n  (oe_strb_n[r]),
            .din   (bus_din),
            .word  (row_words[r]),
            .drive (row_drives[r])
        );
    end

    rowbus_merge #(.ROWS(ROWS), .W(W)) u_merge (
        .words   (row_words),
        .drives  (row_drives),
        .dout    (bus_dout),
        .dout_en (bus_drive)
    );

    // R3
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |-> (&we_strb_n && &oe_strb_n && !bus_drive));
    // R8
    single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~oe_strb_n));
    // R1
    drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_drive |-> (!sel_n && rd_wr_n));
    // R2
    write_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n && !rd_wr_n) |-> (&oe_strb_n && !bus_drive));
    // R10
    released_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive |-> (bus_dout == '0));
endmodule

// File: tb/rowbus_mem_tb.sv
module rowbus_mem_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       sel_n = 1'b1;
    logic       rd_wr_n = 1'b1;
    logic [3:0] bus_din = 4'h0;
    logic [3:0] bus_dout;
    logic       bus_drive;
    logic [3:0] we_strb_n;
    logic [3:0] oe_strb_n;

    int checks = 0;
    int errors = 0;
    logic [3:0] mem_m [4];
    bit done = 1'b0;

    always #5 clk = ~clk;

    rowbus_mem dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .sel_n(sel_n),
        .rd_wr_n(rd_wr_n), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_drive(bus_drive), .we_strb_n(we_strb_n), .oe_strb_n(oe_strb_n)
    );

    // {addr[1:0], sel_n, rd_wr_n, we_strb_n[3:0], oe_strb_n[3:0], bus_drive}
    localparam logic [12:0] VEC [16] = '{
        13'b00_0_1_1111_1110_1,
        13'b01_0_1_1111_1101_1,
        13'b10_0_1_1111_1011_1,
        13'b11_0_1_1111_0111_1,
        13'b00_0_0_1110_1111_0,
        13'b01_0_0_1101_1111_0,
        13'b10_0_0_1011_1111_0,
        13'b11_0_0_0111_1111_0,
        13'b00_1_1_1111_1111_0,
        13'b01_1_1_1111_1111_0,
        13'b10_1_1_1111_1111_0,
        13'b11_1_1_1111_1111_0,
        13'b00_1_0_1111_1111_0,
        13'b01_1_0_1111_1111_0,
        13'b10_1_0_1111_1111_0,
        13'b11_1_0_1111_1111_0
    };

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_row(input logic [1:0] a, input logic [3:0] v);
        @(negedge clk); addr = a; sel_n = 1'b0; rd_wr_n = 1'b0; bus_din = v;
        @(negedge clk); sel_n = 1'b1; rd_wr_n = 1'b1;
        @(negedge clk);
        mem_m[a] = v;
    endtask

    task automatic read_row(input logic [1:0] a, input string tag);
        @(negedge clk); addr = a; sel_n = 1'b0; rd_wr_n = 1'b1;
        #1 chk(bus_drive && bus_dout == mem_m[a], tag, {11'd0, bus_drive, bus_dout}, {11'd0, 1'b1, mem_m[a]});
        @(negedge clk); sel_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        // R11 reset state with chip deselected
        repeat (3) @(negedge clk);
        #1 chk(&we_strb_n && &oe_strb_n && !bus_drive && bus_dout == 4'h0, "R11 reset",
               {7'd0, we_strb_n, oe_strb_n, bus_drive}, {7'd0, 4'hF, 4'hF, 1'b0});
        rst_n = 1'b1;

        // R5 write every row, then read it back
        write_row(2'd0, 4'h3);
        write_row(2'd1, 4'h5);
        write_row(2'd2, 4'hA);
        write_row(2'd3, 4'hC);
        for (int r = 0; r < 4; r++) read_row(2'(r), "R5 readback");

        // R1 R2 R3 decode table walk
        for (int i = 0; i < 16; i++) begin
            logic [12:0] v;
            string tag;
            v = VEC[i];
            @(negedge clk);
            addr = v[12:11]; sel_n = v[10]; rd_wr_n = v[9];
            bus_din = sel_n ? 4'hF : mem_m[addr];
            tag = sel_n ? "R3 decode" : (rd_wr_n ? "R1 decode" : "R2 decode");
            #1;
            chk({we_strb_n, oe_strb_n, bus_drive} == v[8:0], tag,
                {7'd0, we_strb_n, oe_strb_n, bus_drive}, {7'd0, v[8:0]});
            chk(bus_dout == (v[0] ? mem_m[addr] : 4'h0), "R10 bus value",
                {12'd0, bus_dout}, {12'd0, v[0] ? mem_m[addr] : 4'h0});
        end
        @(negedge clk); sel_n = 1'b1; rd_wr_n = 1'b1;
        // R3 deselected write attempts left contents alone
        for (int r = 0; r < 4; r++) read_row(2'(r), "R3 no change");

        // R4 address bit order
        @(negedge clk); addr = 2'b01; sel_n = 1'b0; rd_wr_n = 1'b1;
        #1 chk(oe_strb_n == 4'b1101 && bus_dout == mem_m[1], "R4 addr 01",
               {8'd0, oe_strb_n, bus_dout}, {8'd0, 4'b1101, mem_m[1]});
        @(negedge clk); addr = 2'b10;
        #1 chk(oe_strb_n == 4'b1011 && bus_dout == mem_m[2], "R4 addr 10",
               {8'd0, oe_strb_n, bus_dout}, {8'd0, 4'b1011, mem_m[2]});
        @(negedge clk); sel_n = 1'b1;

        // R5 last value while strobe low wins
        @(negedge clk); addr = 2'd2; sel_n = 1'b0; rd_wr_n = 1'b0; bus_din = 4'h1;
        @(negedge clk); bus_din = 4'h4;
        @(negedge clk); bus_din = 4'h9;
        @(negedge clk); sel_n = 1'b1; rd_wr_n = 1'b1; bus_din = 4'h6;
        @(negedge clk);
        mem_m[2] = 4'h9;
        read_row(2'd2, "R5 last low sample");

        // R6 write then read of the same row in adjacent cycles
        @(negedge clk); addr = 2'd1; sel_n = 1'b0; rd_wr_n = 1'b0; bus_din = 4'hE;
        @(negedge clk); rd_wr_n = 1'b1;
        #1 chk(bus_drive && bus_dout == 4'h5, "R6 old word same cycle",
               {12'd0, bus_dout}, {12'd0, 4'h5});
        @(negedge clk);
        #1 chk(bus_dout == 4'hE, "R6 new word after edge", {12'd0, bus_dout}, {12'd0, 4'hE});
        mem_m[1] = 4'hE;
        @(negedge clk); sel_n = 1'b1;

        // R7 address change during a write
        @(negedge clk); addr = 2'd0; sel_n = 1'b0; rd_wr_n = 1'b0; bus_din = 4'h7;
        @(negedge clk); addr = 2'd3; bus_din = 4'h2;
        #1 chk(we_strb_n == 4'b0111, "R7 new strobe", {12'd0, we_strb_n}, {12'd0, 4'b0111});
        @(negedge clk); sel_n = 1'b1; rd_wr_n = 1'b1;
        @(negedge clk);
        mem_m[0] = 4'h7; mem_m[3] = 4'h2;
        read_row(2'd0, "R7 old row");
        read_row(2'd3, "R7 new row");
        // R9 untouched rows kept their words
        read_row(2'd1, "R9 keep");
        read_row(2'd2, "R9 keep");

        // R8 exclusivity observed over a full read sweep
        for (int r = 0; r < 4; r++) begin
            @(negedge clk); addr = 2'(r); sel_n = 1'b0; rd_wr_n = 1'b1;
            #1 chk($countones(~oe_strb_n) == 1 && ((we_strb_n | oe_strb_n) == 4'hF), "R8 single driver",
                   {8'd0, we_strb_n, oe_strb_n}, {8'd0, 4'hF, ~(4'b1 << r)});
        end
        @(negedge clk); sel_n = 1'b1;

        done = 1'b1;
        finish_run();
    end
endmodule